// File: doc/BRIEF.md
# Serial EEPROM Write-Protection Controller

This block decides whether a write to the status register or to the memory array of a serial EEPROM may go ahead. The array has 64K byte addresses. The block holds the protection fields of the status register: a status-write-lock bit, a two-bit block-guard code and a write-enable latch. Each one-cycle command strobe gets an accept or reject decision one clock later. The strobes come from the opcode decoder: arm, disarm, status write with its data byte, and memory write with its 16-bit address. The live active-low write-protect pin and the lock bit together make up a hardware-lock mode, which is reported on its own output.

All interfaces are plain control and status pins. A request carries no data stream and there is no back-pressure: the block consumes every strobe in the cycle it is asserted. An accepted decision is the cue for the rest of the device to start the nonvolatile write. SPI shifting, opcode decoding, the array itself and write-cycle timing all sit outside this block. The busy flag from the write timer is only mirrored into the status byte.

Top module: `eeprom_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 00h (with busy low), all four decision flags are 0, and the hardware-lock output is 0.
- R2: An arm strobe sets the write-enable latch, which shows as status bit 1 one clock later. A disarm strobe clears it.
- R3: A status write made while the latch is clear is rejected and leaves status bits 7 and 3:2 unchanged.
- R4: While the lock bit (status bit 7) is 0, a status write with the latch set is accepted whatever the pin level. It loads data bit 7 into the lock bit and data bits 3:2 into the block-guard code (status bits 3:2), and ignores all other data bits.
- R5: While the lock bit is 1 and the pin is low, a status write is rejected even with the latch set, and the lock bit and block-guard code keep their values.
- R6: While the lock bit is 1 and the pin is high, a status write with the latch set is accepted.
- R7: The hardware-lock output is 1 exactly while the lock bit is 1 and the pin is low, whichever of the two became true first. It drops as soon as the pin goes high.
- R8: Block-guard code 00 guards no address, 01 guards C000h-FFFFh, 10 guards 8000h-FFFFh and 11 guards every address. A memory write to a guarded address is rejected.
- R9: A memory write with the latch set to an unguarded address is accepted, both with and without hardware lock.
- R10: A memory write made while the latch is clear is rejected.
- R11: Any status or memory write strobe, whether accepted or rejected, leaves the latch clear afterwards.
- R12: Each write strobe produces exactly one of its accept or reject flags, for one cycle, on the clock after the strobe. A cycle without that strobe produces neither.
- R13: Status bit 0 mirrors the busy input and bits 6:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Write-enable command strobe |
| disarm_i | input | 1 | Write-disable command strobe |
| sr_wr_i | input | 1 | Status-register write strobe |
| sr_data_i | input | 8 | Data byte of the status write |
| mem_wr_i | input | 1 | Memory write strobe |
| mem_addr_i | input | 16 | Byte address of the memory write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Write-in-progress from the write timer |
| sr_accept_o | output | 1 | Status write accepted |
| sr_reject_o | output | 1 | Status write rejected |
| mem_accept_o | output | 1 | Memory write accepted |
| mem_reject_o | output | 1 | Memory write rejected |
| status_o | output | 8 | Current status byte |
| hw_lock_o | output | 1 | Hardware-lock mode active |

## Verification
Every protection field is visible in the status byte one clock after the strobe that changed it. A wrong latch, lock bit or guard code therefore shows at the ports on the next cycle, before any write depends on it. A wrong decision shows on the accept/reject flags in the single cycle after the write strobe. The bench reads the status byte after every command, so a stray field change is caught at the command that caused it and not several writes later.

// File: rtl/eewp_pkg.sv
package eewp_pkg;
  localparam int SR_W      = 8;
  localparam int LOCK_BIT  = 7;
  localparam int GUARD_HI  = 3;
  localparam int GUARD_LO  = 2;
  localparam int LATCH_BIT = 1;
  localparam int BUSY_BIT  = 0;
  localparam int GUARD_W   = GUARD_HI - GUARD_LO + 1;

  typedef logic [GUARD_W-1:0] guard_t;

  typedef enum logic [1:0] {
    GUARD_NONE    = 2'b00,
    GUARD_QUARTER = 2'b01,
    GUARD_HALF    = 2'b10,
    GUARD_ALL     = 2'b11
  } guard_e;
endpackage

// File: rtl/eewp_latch.sv
module eewp_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (clr_i)  q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
  end

  // R2: arm without a clearing strobe sets the latch on the next clock
  a_r2_arm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> q_o);
  // R11: a clearing strobe always leaves the latch low
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !q_o);
endmodule

// File: rtl/eewp_fields.sv
module eewp_fields
  import eewp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  logic   lock_d_i,
  input  guard_t guard_d_i,
  output logic   lock_o,
  output guard_t guard_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_o  <= 1'b0;
      guard_o <= '0;
    end else if (load_i) begin
      lock_o  <= lock_d_i;
      guard_o <= guard_d_i;
    end
  end

  // R3/R5: the fields move only when a load was granted
  a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(lock_o) && $stable(guard_o)));
endmodule

// File: rtl/eewp_region.sv
module eewp_region
  import eewp_pkg::*;
(
  input  guard_t     guard_i,
  input  logic [1:0] addr_top_i,
  output logic       hit_o
);
  always_comb begin
    unique case (guard_e'(guard_i))
      GUARD_NONE:    hit_o = 1'b0;
      GUARD_QUARTER: hit_o = &addr_top_i;
      GUARD_HALF:    hit_o = addr_top_i[1];
      GUARD_ALL:     hit_o = 1'b1;
      default:       hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/eeprom_wp_ctrl.sv
module eeprom_wp_ctrl
  import eewp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              disarm_i,
  input  logic              sr_wr_i,
  input  logic [SR_W-1:0]   sr_data_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  output logic              sr_accept_o,
  output logic              sr_reject_o,
  output logic              mem_accept_o,
  output logic              mem_reject_o,
  output logic [SR_W-1:0]   status_o,
  output logic              hw_lock_o
);
  localparam int TOP = ADDR_W - 1;

  logic   latch_q, lock_q, guard_hit;
  guard_t guard_q;
  logic   sr_grant, mem_grant, latch_clr;
  logic   unused_bits;

  assign unused_bits = ^{sr_data_i[6:4], sr_data_i[1:0], mem_addr_i[TOP-2:0]};

  assign hw_lock_o = lock_q & ~wp_n_i;
  assign sr_grant  = sr_wr_i & latch_q & ~hw_lock_o;
  assign mem_grant = mem_wr_i & latch_q & ~guard_hit;
  assign latch_clr = disarm_i | sr_wr_i | mem_wr_i;

  eewp_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (arm_i),
    .clr_i (latch_clr),
    .q_o   (latch_q)
  );

  eewp_fields u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (sr_grant),
    .lock_d_i  (sr_data_i[LOCK_BIT]),
    .guard_d_i (sr_data_i[GUARD_HI:GUARD_LO]),
    .lock_o    (lock_q),
    .guard_o   (guard_q)
  );

  eewp_region u_region (
    .guard_i    (guard_q),
    .addr_top_i (mem_addr_i[TOP:TOP-1]),
    .hit_o      (guard_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_accept_o  <= 1'b0;
      sr_reject_o  <= 1'b0;
      mem_accept_o <= 1'b0;
      mem_reject_o <= 1'b0;
    end else begin
      sr_accept_o  <= sr_grant;
      sr_reject_o  <= sr_wr_i & ~sr_grant;
      mem_accept_o <= mem_grant;
      mem_reject_o <= mem_wr_i & ~mem_grant;
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[LOCK_BIT]  = lock_q;
    status_o[GUARD_HI:GUARD_LO] = guard_q;
    status_o[LATCH_BIT] = latch_q;
    status_o[BUSY_BIT]  = busy_i;
  end

  // R12: a flag appears only on the clock after its strobe
  a_r12_sr_flag_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_accept_o || sr_reject_o) |-> $past(sr_wr_i));
  a_r12_mem_flag_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_accept_o || mem_reject_o) |-> $past(mem_wr_i));
  a_r12_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_accept_o, sr_reject_o}) && $onehot0({mem_accept_o, mem_reject_o}));
  // R3: no latch, no status write
  a_r3_no_latch_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && !status_o[LATCH_BIT]) |=> sr_reject_o);
  // R5: lock bit plus low pin rejects status writes
  a_r5_hw_lock_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_wr_i && status_o[LOCK_BIT] && !wp_n_i) |=> sr_reject_o);
  // R8: whole-array guard rejects every memory write
  a_r8_all_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_i && status_o[GUARD_HI:GUARD_LO] == 2'b11) |=> mem_reject_o);
  // R10: no latch, no memory write
  a_r10_mem_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_i && !status_o[LATCH_BIT]) |=> mem_reject_o);
  // R13: unused status bits stay zero
  a_r13_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);
endmodule

// File: tb/eeprom_wp_ctrl_test.sv
module eeprom_wp_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm_i = 0, disarm_i = 0, sr_wr_i = 0, mem_wr_i = 0;
  logic [7:0]  sr_data_i = 0;
  logic [15:0] mem_addr_i = 0;
  logic        wp_n_i = 1, busy_i = 0;
  logic        sr_accept_o, sr_reject_o, mem_accept_o, mem_reject_o, hw_lock_o;
  logic [7:0]  status_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  eeprom_wp_ctrl uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .disarm_i(disarm_i),
    .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .mem_wr_i(mem_wr_i),
    .mem_addr_i(mem_addr_i), .wp_n_i(wp_n_i), .busy_i(busy_i),
    .sr_accept_o(sr_accept_o), .sr_reject_o(sr_reject_o),
    .mem_accept_o(mem_accept_o), .mem_reject_o(mem_reject_o),
    .status_o(status_o), .hw_lock_o(hw_lock_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // op: 0 arm, 1 disarm, 2 status write, 3 memory write
  localparam int NV = 28;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h02},  // R2
    {2'd2, 1'b1, 16'h008C, 1'b1, 8'h8C},  // R4
    {2'd3, 1'b1, 16'h0000, 1'b0, 8'h8C},  // R10
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h8E},
    {2'd3, 1'b1, 16'h0000, 1'b0, 8'h8C},  // R8 all, R11
    {2'd0, 1'b0, 16'h0000, 1'b0, 8'h8E},
    {2'd2, 1'b0, 16'h0000, 1'b0, 8'h8C},  // R5
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h8E},
    {2'd2, 1'b1, 16'h0084, 1'b1, 8'h84},  // R6
    {2'd0, 1'b0, 16'h0000, 1'b0, 8'h86},
    {2'd3, 1'b0, 16'hBFFF, 1'b1, 8'h84},  // R9 under lock
    {2'd0, 1'b0, 16'h0000, 1'b0, 8'h86},
    {2'd3, 1'b0, 16'hC000, 1'b0, 8'h84},  // R8 quarter
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h86},
    {2'd2, 1'b1, 16'h0008, 1'b1, 8'h08},  // R6
    {2'd0, 1'b0, 16'h0000, 1'b0, 8'h0A},
    {2'd3, 1'b0, 16'h7FFF, 1'b1, 8'h08},  // R9
    {2'd0, 1'b0, 16'h0000, 1'b0, 8'h0A},
    {2'd3, 1'b0, 16'h8000, 1'b0, 8'h08},  // R8 half
    {2'd0, 1'b0, 16'h0000, 1'b0, 8'h0A},
    {2'd2, 1'b0, 16'h0000, 1'b1, 8'h00},  // R4 pin low
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h02},
    {2'd3, 1'b1, 16'hFFFF, 1'b1, 8'h00},  // R8 none
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h02},
    {2'd1, 1'b1, 16'h0000, 1'b0, 8'h00},  // R2 disarm
    {2'd2, 1'b1, 16'h008C, 1'b0, 8'h00},  // R3
    {2'd0, 1'b1, 16'h0000, 1'b0, 8'h02},
    {2'd2, 1'b1, 16'h00F3, 1'b1, 8'h80}   // R4 ignored bits, R13
  };

  task automatic run_op(input logic [1:0] op, input logic wp, input logic [15:0] val);
    @(negedge clk);
    wp_n_i = wp;
    arm_i = (op == 2'd0); disarm_i = (op == 2'd1);
    sr_wr_i = (op == 2'd2); mem_wr_i = (op == 2'd3);
    sr_data_i = val[7:0]; mem_addr_i = val;
    @(negedge clk);
    arm_i = 0; disarm_i = 0; sr_wr_i = 0; mem_wr_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", {8'h0, status_o}, 16'h0000);
    check("R1 flags", {12'h0, sr_accept_o, sr_reject_o, mem_accept_o, mem_reject_o}, 16'h0);
    check("R1 hw lock", {15'h0, hw_lock_o}, 16'h0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic wp, ok;
      logic [15:0] val;
      logic [7:0] st;
      {op, wp, val, ok, st} = VEC[i];
      run_op(op, wp, val);
      check($sformatf("R2/R3/R4/R5/R6 status row %0d", i), {8'h0, status_o}, {8'h0, st});
      check($sformatf("R7 hw lock row %0d", i), {15'h0, hw_lock_o}, {15'h0, st[7] & ~wp});
      if (op == 2'd2)
        check($sformatf("R12 sr flags row %0d", i), {14'h0, sr_accept_o, sr_reject_o}, {14'h0, ok, ~ok});
      else if (op == 2'd3)
        check($sformatf("R8/R9/R10 mem flags row %0d", i), {14'h0, mem_accept_o, mem_reject_o}, {14'h0, ok, ~ok});
      else
        check($sformatf("R12 no flags row %0d", i),
              {12'h0, sr_accept_o, sr_reject_o, mem_accept_o, mem_reject_o}, 16'h0);
    end

    // R12: flags last a single cycle
    @(negedge clk);
    check("R12 flag drops", {14'h0, sr_accept_o, sr_reject_o}, 16'h0);

    // R7: lock bit set first, then pin falls, then pin rises
    wp_n_i = 1; @(negedge clk);
    check("R7 pin high no lock", {15'h0, hw_lock_o}, 16'h0);
    wp_n_i = 0; #1;
    check("R7 pin low after lock bit", {15'h0, hw_lock_o}, 16'h1);
    wp_n_i = 1; #1;
    check("R7 exit on pin high", {15'h0, hw_lock_o}, 16'h0);

    // R13: busy mirror
    busy_i = 1; #1;
    check("R13 busy mirror", {8'h0, status_o}, 16'h0081);
    busy_i = 0; #1;
    check("R13 busy clear", {8'h0, status_o}, 16'h0080);

    // R11: rejected memory write while armed clears latch
    run_op(2'd0, 1'b1, 16'h0);
    run_op(2'd2, 1'b1, 16'h000C);  // lock off, guard all
    run_op(2'd0, 1'b1, 16'h0);
    run_op(2'd3, 1'b1, 16'h1234);
    check("R8 guard all reject", {14'h0, mem_accept_o, mem_reject_o}, 16'h1);
    check("R11 latch clear after reject", {8'h0, status_o}, 16'h000C);

    // R1: reset mid-run restores defaults
    rst_n = 0; #1;
    check("R1 reset again", {8'h0, status_o}, 16'h0000);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule